// File: doc/BRIEF.md
# Serial-Bus Control Register Slave

This block is a two-wire serial-bus slave that gives a host read and write access to a small bank of 8-bit control registers. A fast system clock oversamples the clock and data lines. The block detects start, stop and repeated-start conditions, matches its fixed 7-bit device address, and acknowledges the bytes it accepts. It pulls the data line low through a single open-drain control output, and it never drives the line high.

Every transaction begins with a command byte. Bit 7 of that byte selects the mode: 1 is single-byte mode and 0 is block mode. The low bits give the first register index. A read sends the command in a write phase, then a repeated start, then the address again with the read bit set. In block mode a byte count comes before the data. On a write the host sends the count first. On a read the slave returns the count first, and its value is the number of registers. The register pointer steps forward after each data byte and wraps around the bank.

Register 0 holds the enable bits for seven output pairs. A cleared bit tri-states its pair. After reset every enable bit is set, so every output is driven.

Top module: `smb_regbank`

## Requirements
- R1: After reset, register 0 is 8'hFF and every other register is 8'h00. en_o is 7'h7F and sda_pull_o is 0 (line released).
- R2: The first byte after a start is {address[6:0], rw}. The slave pulls SDA low in the acknowledge slot only when the address equals DEV_ADDR (default 7'h69). For any other address it does not acknowledge that byte or any later byte, and it stores nothing until the next start.
- R3: A command byte with bit 7 = 1 selects byte mode, and bits [AW-1:0] give the register index. The slave acknowledges the command byte and the one data byte, and stores the data in that register only.
- R4: A byte-mode read follows this order: write-phase command, repeated start, address with rw = 1. The slave returns the addressed register MSB first. When the host answers with NACK, the slave leaves SDA released.
- R5: A command byte with bit 7 = 0 selects block mode. On a write, the first data byte is a count and is not stored. The slave acknowledges every byte, and each later byte goes to the next register in turn, starting at the command index.
- R6: A block-mode read returns a count byte equal to NREG (8 by default) first. It then returns consecutive registers from the command index. Each host ACK brings the next byte, and a NACK ends the transfer.
- R7: en_o[k-1] equals register 0 bit k for k = 1 to 7. A write of 0 to a bit disables its output pair. Register 0 bit 0 always reads 1, whatever value is written to it.
- R8: A start condition (SDA falls while SCL is high) or a stop condition (SDA rises while SCL is high) resets the bit counter at any point, including in the middle of a byte. A transfer that follows a start in mid-byte works normally, and a stop leaves SDA released.
- R9: The slave changes sda_pull_o only while SCL is low.
- R10: The register pointer wraps from index NREG-1 back to 0 during a block transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| en_o | output | 7 | Output-pair enables, equal to register 0 bits 7:1 |
| regs_o | output | NREG*8 | All registers; register i sits at bits [8i+7:8i] |

## Verification
The bench sends a write to a foreign address and then a command and a data byte. A slave that mishandles the address would acknowledge those bytes or change a register. Block writes and block reads check the count byte: a design that stores the count, or skips it, would put every data byte in the wrong register. A block write that starts at the last index exposes a pointer that does not wrap around. A start issued in the middle of the address byte shows whether the bit counter realigns, and a write of 0 to register 0 bit 0 must read back as 1.

// File: rtl/smb_regbank_pkg.sv
package smb_regbank_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_CMD,
    S_CACK,
    S_WDATA,
    S_WACK,
    S_RDATA,
    S_RACK
  } bus_st_t;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] ff;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) ff[0] <= 1'b1;
          else     ff[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) ff[i] <= 1'b1;
          else     ff[i] <= ff[i-1];
        end
      end
    end
  endgenerate

  assign dout = ff[STAGES-1];
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int         NREG    = 8,
  parameter int         AW      = 3,
  parameter logic [7:0] R0_INIT = 8'hFF,
  parameter logic [7:0] RX_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [7:0]        wdata,
  input  logic [AW-1:0]     raddr,
  output logic [7:0]        rdata,
  output logic [NREG*8-1:0] flat
);
  logic [7:0] mem [NREG];

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0) begin : g_r0
        // bit 0 is reserved and always holds 1
        always_ff @(posedge clk) begin
          if (rst)                       mem[i] <= R0_INIT;
          else if (we && waddr == AW'(i)) mem[i] <= {wdata[7:1], 1'b1};
        end
      end else begin : g_rx
        always_ff @(posedge clk) begin
          if (rst)                       mem[i] <= RX_INIT;
          else if (we && waddr == AW'(i)) mem[i] <= wdata;
        end
      end
      assign flat[i*8 +: 8] = mem[i];
    end
  endgenerate

  assign rdata = mem[raddr];
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
  import smb_regbank_pkg::*;
#(
  parameter int         NREG     = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         SYNC_FF  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [6:0]        en_o,
  output logic [NREG*8-1:0] regs_o
);
  localparam int         AW       = $clog2(NREG);
  localparam logic [7:0] CNT_BYTE = 8'(NREG);

  logic scl_s, sda_s, scl_p, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det;

  smb_sync #(.STAGES(SYNC_FF)) u_scl (.clk(clk), .rst(rst), .din(scl_i), .dout(scl_s));
  smb_sync #(.STAGES(SYNC_FF)) u_sda (.clk(clk), .rst(rst), .din(sda_i), .dout(sda_p_in));

  logic sda_p_in;
  assign sda_s = sda_p_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_p;
  assign scl_fall  = ~scl_s &  scl_p;
  assign start_det =  scl_s &  scl_p &  sda_p & ~sda_s;
  assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_s;

  bus_st_t       st;
  logic [3:0]    cnt;
  logic [7:0]    sr, tx;
  logic [AW-1:0] ptr;
  logic          rw, blk, hdr, mack, pull;
  logic          we;
  logic [AW-1:0] wa;
  logic [7:0]    wd;
  logic [7:0]    rd_byte, nxt_byte;

  assign nxt_byte = hdr ? CNT_BYTE : rd_byte;

  always_ff @(posedge clk) begin
    we <= 1'b0;
    if (rst) begin
      st   <= S_IDLE;
      cnt  <= '0;
      sr   <= '0;
      tx   <= '0;
      ptr  <= '0;
      rw   <= 1'b0;
      blk  <= 1'b0;
      hdr  <= 1'b0;
      mack <= 1'b0;
      pull <= 1'b0;
      wa   <= '0;
      wd   <= '0;
    end else if (start_det) begin
      st   <= S_ADDR;
      cnt  <= '0;
      pull <= 1'b0;
    end else if (stop_det) begin
      st   <= S_IDLE;
      cnt  <= '0;
      pull <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_CMD, S_WDATA: begin
          if (scl_rise) begin
            sr  <= {sr[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (st == S_ADDR) begin
              if (sr[7:1] == DEV_ADDR) begin
                pull <= 1'b1;
                rw   <= sr[0];
                st   <= S_AACK;
                if (sr[0]) hdr <= blk;
              end else begin
                st <= S_IDLE;
              end
            end else if (st == S_CMD) begin
              pull <= 1'b1;
              blk  <= ~sr[7];
              hdr  <= ~sr[7];
              ptr  <= sr[AW-1:0];
              st   <= S_CACK;
            end else begin
              pull <= 1'b1;
              st   <= S_WACK;
              if (hdr) begin
                hdr <= 1'b0;
              end else begin
                we  <= 1'b1;
                wa  <= ptr;
                wd  <= sr;
                ptr <= ptr + 1'b1;
              end
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx   <= nxt_byte;
              pull <= ~nxt_byte[7];
              st   <= S_RDATA;
              if (hdr) hdr <= 1'b0;
              else     ptr <= ptr + 1'b1;
            end else begin
              pull <= 1'b0;
              st   <= S_CMD;
            end
          end
        end
        S_CACK, S_WACK: begin
          if (scl_fall) begin
            pull <= 1'b0;
            cnt  <= '0;
            st   <= S_WDATA;
          end
        end
        S_RDATA: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              pull <= 1'b0;
              cnt  <= '0;
              st   <= S_RACK;
            end else begin
              pull <= ~tx[6];
              tx   <= {tx[6:0], 1'b0};
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              tx   <= nxt_byte;
              pull <= ~nxt_byte[7];
              st   <= S_RDATA;
              if (hdr) hdr <= 1'b0;
              else     ptr <= ptr + 1'b1;
            end else begin
              pull <= 1'b0;
              st   <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  smb_regfile #(
    .NREG(NREG), .AW(AW), .R0_INIT(8'hFF), .RX_INIT(8'h00)
  ) u_regs (
    .clk(clk), .rst(rst), .we(we), .waddr(wa), .wdata(wd),
    .raddr(ptr), .rdata(rd_byte), .flat(regs_o)
  );

  assign sda_pull_o = pull;
  assign en_o       = regs_o[7:1];
endmodule

// File: rtl/smb_regbank_chk.sv
module smb_regbank_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl,
  input logic       pull,
  input logic [6:0] en,
  input logic       r0b0,
  input logic       start_det,
  input logic       stop_det
);
  // R9
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pull) |-> !scl);

  // R7
  reg0_bit0_chk: assert property (@(posedge clk) disable iff (rst)
    r0b0 == 1'b1);

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !pull);

  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !pull);

  // R1
  reset_enables_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (en == 7'h7F && !pull));
endmodule

bind smb_regbank smb_regbank_chk u_chk (
  .clk(clk), .rst(rst), .scl(scl_i), .pull(sda_pull_o), .en(en_o),
  .r0b0(regs_o[0]), .start_det(start_det), .stop_det(stop_det)
);

// File: tb/tb_smb_regbank.sv
module tb_smb_regbank;
  localparam int         NREG = 8;
  localparam logic [6:0] ADDR = 7'h69;
  localparam int         Q    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_line;
  logic sda_pull;
  logic [6:0] en;
  logic [NREG*8-1:0] regs;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] exp_r [NREG];

  always #5 clk = ~clk;

  assign sda_line = ~(m_low | sda_pull);

  smb_regbank #(.NREG(NREG), .DEV_ADDR(ADDR)) dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .en_o(en), .regs_o(regs)
  );

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [NREG*8-1:0] packed_exp();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = exp_r[i];
    return v;
  endfunction

  task automatic bus_start();
    m_low = 1'b0; wq();
    scl = 1'b1;   wq();
    m_low = 1'b1; wq();
    scl = 1'b0;   wq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq();
    scl = 1'b1;   wq();
    m_low = 1'b0; wq(); wq();
  endtask

  task automatic send_bit(input logic b);
    m_low = ~b; wq();
    scl = 1'b1; wq(); wq();
    scl = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    m_low = 1'b0; wq();
    scl = 1'b1;   wq();
    b = sda_line; wq();
    scl = 1'b0;   wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~ack);
  endtask

  task automatic t_reset();
    chk("R1 en_o", 64'(en), 64'h7F);
    chk("R1 regs", regs, packed_exp());
    chk("R1 sda released", 64'(sda_pull), 64'h0);
  endtask

  task automatic t_byte_write();
    logic a0, a1, a2;
    bus_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(8'h83, a1);
    send_byte(8'hA5, a2);
    bus_stop();
    exp_r[3] = 8'hA5;
    chk("R2 addr ack", 64'(a0), 64'h1);
    chk("R3 cmd/data ack", 64'({a1, a2}), 64'h3);
    chk("R3 byte write regs", regs, packed_exp());
  endtask

  task automatic t_byte_read();
    logic a0, a1, a2;
    logic [7:0] d;
    bus_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(8'h83, a1);
    bus_start();
    send_byte({ADDR, 1'b1}, a2);
    recv_byte(d, 1'b0);
    wq();
    chk("R4 released after nack", 64'(sda_line), 64'h1);
    bus_stop();
    chk("R4 acks", 64'({a0, a1, a2}), 64'h7);
    chk("R4 read data", 64'(d), 64'hA5);
  endtask

  task automatic t_bad_addr();
    logic a0, a1, a2;
    bus_start();
    send_byte({7'h12, 1'b0}, a0);
    send_byte(8'h84, a1);
    send_byte(8'h77, a2);
    bus_stop();
    chk("R2 no ack foreign", 64'({a0, a1, a2}), 64'h0);
    chk("R2 foreign ignored", regs, packed_exp());
  endtask

  task automatic t_block_write();
    logic a0, a1, a2, a3, a4, a5;
    bus_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(8'h01, a1);
    send_byte(8'h03, a2);
    send_byte(8'h11, a3);
    send_byte(8'h22, a4);
    send_byte(8'h33, a5);
    bus_stop();
    exp_r[1] = 8'h11; exp_r[2] = 8'h22; exp_r[3] = 8'h33;
    chk("R5 all acked", 64'({a0, a1, a2, a3, a4, a5}), 64'h3F);
    chk("R5 block write regs", regs, packed_exp());
  endtask

  task automatic t_block_read();
    logic a0, a1, a2;
    logic [7:0] c, d1, d2, d3;
    bus_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(8'h01, a1);
    bus_start();
    send_byte({ADDR, 1'b1}, a2);
    recv_byte(c, 1'b1);
    recv_byte(d1, 1'b1);
    recv_byte(d2, 1'b1);
    recv_byte(d3, 1'b0);
    wq();
    chk("R6 released after nack", 64'(sda_line), 64'h1);
    bus_stop();
    chk("R6 acks", 64'({a0, a1, a2}), 64'h7);
    chk("R6 count byte", 64'(c), 64'(NREG));
    chk("R6 data bytes", 64'({d1, d2, d3}), 64'h112233);
  endtask

  task automatic t_reg0();
    logic a0, a1, a2, a3;
    logic [7:0] d;
    bus_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(8'h80, a1);
    send_byte(8'h54, a2);
    bus_stop();
    exp_r[0] = 8'h55;
    chk("R7 en_o", 64'(en), 64'h2A);
    chk("R7 regs", regs, packed_exp());
    bus_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(8'h80, a1);
    bus_start();
    send_byte({ADDR, 1'b1}, a3);
    recv_byte(d, 1'b0);
    bus_stop();
    chk("R7 bit0 reads 1", 64'(d), 64'h55);
  endtask

  task automatic t_abort();
    logic a0, a1, a2;
    bus_start();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(8'h85, a1);
    send_byte(8'h5A, a2);
    bus_stop();
    exp_r[5] = 8'h5A;
    chk("R8 acks after restart", 64'({a0, a1, a2}), 64'h7);
    chk("R8 regs after restart", regs, packed_exp());
    chk("R8 released after stop", 64'(sda_pull), 64'h0);
  endtask

  task automatic t_wrap();
    logic a0, a1, a2, a3, a4;
    bus_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(8'h07, a1);
    send_byte(8'h02, a2);
    send_byte(8'hC1, a3);
    send_byte(8'hC2, a4);
    bus_stop();
    exp_r[7] = 8'hC1; exp_r[0] = 8'hC3;
    chk("R10 acks", 64'({a0, a1, a2, a3, a4}), 64'h1F);
    chk("R10 wrap regs", regs, packed_exp());
    chk("R10 en_o after wrap", 64'(en), 64'h61);
  endtask

  initial begin
    exp_r[0] = 8'hFF;
    for (int i = 1; i < NREG; i++) exp_r[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_byte_write();
    t_byte_read();
    t_bad_addr();
    t_block_write();
    t_block_read();
    t_reg0();
    t_abort();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule